// File: doc/BRIEF.md
# Six-Stage In-Order Pipeline Hazard Controller

This block steers instruction descriptors through a six-stage in-order pipeline. The stages, in order, are instruction fetch, decode, operand address calculation, operand read, execute and result write. It keeps a valid bit and a descriptor for each stage. The descriptor holds a program address, an optional destination tag, an optional source tag and branch information. The block does not compute anything itself. It decides each cycle whether the pipe advances, holds its front half, or discards younger work.

Descriptors arrive from a fetch source over a valid/ready handshake. A descriptor is taken on a cycle where both `in_valid` and `in_ready` are high. `in_ready` falls during a stall or a flush. While `in_valid` is high and `in_ready` is low, the source must keep the descriptor unchanged. The one exception is a flush cycle, where the source drops the held descriptor and restarts at `redirect_pc`. Operands are read in the fourth stage and results are written in the sixth. A write in the sixth stage is seen in the same cycle by the operand read, so only the execute stage can cause a read-after-write stall. Branches resolve in execute.

Free-running cycle and retirement counters let a test confirm pipelined throughput.

Top module: `pl_hazard_ctrl`

## Requirements
- R1: After reset, all six `stage_valid` bits are 0. `stall`, `flush`, `cycle_cnt` and `retired_cnt` are 0, and `in_ready` is 1.
- R2: With no stall and no flush, `in_ready` is 1. An accepted descriptor sets `stage_valid[0]` at the next edge and moves one stage per edge. `stage_valid` bit k is stage k, with 0 = fetch and 5 = write. `wr_pc` shows the address held in the write stage.
- R3: Nine independent descriptors offered on back-to-back cycles after reset all reach the write stage at edge 14. At that point `cycle_cnt` = 14 and `retired_cnt` = 9.
- R4: `stall` is high in the same cycle when all of the following hold: the operand-read stage is valid with its source enabled, the execute stage is valid with its destination enabled, the two tags are equal, and there is no flush. `in_ready` is low during that cycle.
- R5: On a stall, stages 0–3 keep their contents, execute takes a bubble, and the write stage takes the old execute content.
- R6: A source tag that matches only the destination in the write stage causes no stall.
- R7: `flush` is high in the same cycle when the execute stage is valid, marked as a branch and marked taken. `redirect_pc` then equals that branch's target.
- R8: At the edge after a flush, stages 0–4 are empty and the branch moves to the write stage.
- R9: When a flush and a tag match occur in the same cycle, `flush` is 1 and `stall` is 0.
- R10: A branch that is not taken causes no flush, and all descriptors that follow it retire.
- R11: `cycle_cnt` increases by one on every edge out of reset. `retired_cnt` increases by one on each edge at which a valid instruction enters the write stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor taken this cycle if offered |
| in_pc | input | ADDR_W | Descriptor program address |
| in_dst | input | TAG_W | Destination register tag |
| in_dst_en | input | 1 | Destination tag is used |
| in_src | input | TAG_W | Source register tag |
| in_src_en | input | 1 | Source tag is used |
| in_is_br | input | 1 | Descriptor is a conditional branch |
| in_br_taken | input | 1 | Branch outcome, used in execute |
| in_br_target | input | ADDR_W | Branch destination address |
| stage_valid | output | 6 | Per-stage valid, bit 0 fetch to bit 5 write |
| stall | output | 1 | Read-after-write hold this cycle |
| flush | output | 1 | Taken branch in execute this cycle |
| redirect_pc | output | ADDR_W | Restart address, meaningful with flush |
| wr_pc | output | ADDR_W | Address of the instruction in the write stage |
| cycle_cnt | output | CNT_W | Edges since reset |
| retired_cnt | output | CNT_W | Instructions that reached the write stage |

## Verification
The checker assumes the fetch source follows the handshake. It holds an unaccepted descriptor steady, except in a flush cycle, where it may abandon it. It also assumes the branch-taken flag matters only when the branch flag is set. The random fetch source in the bench keeps one pending descriptor until that descriptor is accepted or flushed, then moves its next address to the redirect target. It draws tags from a small range so that dependencies, including those that coincide with a taken branch, occur often.

// File: rtl/pl_ctrl_pkg.sv
package pl_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_FI = 3'd0,
    ST_DI = 3'd1,
    ST_OC = 3'd2,
    ST_OF = 3'd3,
    ST_EX = 3'd4,
    ST_WR = 3'd5
  } stage_e;

  localparam int NUM_ST = 6;
  localparam int IDX_OF = int'(ST_OF);
  localparam int IDX_EX = int'(ST_EX);
  localparam int IDX_WR = int'(ST_WR);

endpackage

// File: rtl/pl_stage_pipe.sv
module pl_stage_pipe
  import pl_ctrl_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              hold,
  input  logic              kill,
  input  logic [ADDR_W-1:0] d_pc,
  input  logic [TAG_W-1:0]  d_dst,
  input  logic              d_dst_en,
  input  logic [TAG_W-1:0]  d_src,
  input  logic              d_src_en,
  input  logic              d_is_br,
  input  logic              d_taken,
  input  logic [ADDR_W-1:0] d_target,
  output logic [NUM_ST-1:0] v_o,
  output logic              of_src_en,
  output logic [TAG_W-1:0]  of_src,
  output logic              ex_dst_en,
  output logic [TAG_W-1:0]  ex_dst,
  output logic              ex_is_br,
  output logic              ex_taken,
  output logic [ADDR_W-1:0] ex_target,
  output logic [ADDR_W-1:0] wr_pc_o
);

  typedef struct packed {
    logic [ADDR_W-1:0] pc;
    logic [TAG_W-1:0]  dst;
    logic              dst_en;
    logic [TAG_W-1:0]  src;
    logic              src_en;
    logic              is_br;
    logic              taken;
    logic [ADDR_W-1:0] target;
  } desc_t;

  desc_t stg_d [NUM_ST];
  logic  stg_v [NUM_ST];
  desc_t in_d;

  always_comb begin
    in_d.pc     = d_pc;
    in_d.dst    = d_dst;
    in_d.dst_en = d_dst_en;
    in_d.src    = d_src;
    in_d.src_en = d_src_en;
    in_d.is_br  = d_is_br;
    in_d.taken  = d_taken;
    in_d.target = d_target;
  end

  for (genvar k = 0; k < NUM_ST; k++) begin : g_stg
    desc_t nxt_d;
    logic  nxt_v;

    if (k == 0) begin : g_head
      always_comb begin
        nxt_d = stg_d[k];
        nxt_v = stg_v[k];
        if (kill) begin
          nxt_v = 1'b0;
        end else if (!hold) begin
          nxt_v = accept;
          nxt_d = in_d;
        end
      end
    end else if (k < IDX_EX) begin : g_front
      always_comb begin
        nxt_d = stg_d[k];
        nxt_v = stg_v[k];
        if (kill) begin
          nxt_v = 1'b0;
        end else if (!hold) begin
          nxt_v = stg_v[k-1];
          nxt_d = stg_d[k-1];
        end
      end
    end else if (k == IDX_EX) begin : g_exec
      always_comb begin
        nxt_d = stg_d[k-1];
        nxt_v = stg_v[k-1] && !kill && !hold;
      end
    end else begin : g_tail
      always_comb begin
        nxt_d = stg_d[k-1];
        nxt_v = stg_v[k-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_v[k] <= 1'b0;
        stg_d[k] <= '0;
      end else begin
        stg_v[k] <= nxt_v;
        stg_d[k] <= nxt_d;
      end
    end

    assign v_o[k] = stg_v[k];
  end

  assign of_src_en = stg_d[IDX_OF].src_en;
  assign of_src    = stg_d[IDX_OF].src;
  assign ex_dst_en = stg_d[IDX_EX].dst_en;
  assign ex_dst    = stg_d[IDX_EX].dst;
  assign ex_is_br  = stg_d[IDX_EX].is_br;
  assign ex_taken  = stg_d[IDX_EX].taken;
  assign ex_target = stg_d[IDX_EX].target;
  assign wr_pc_o   = stg_d[IDX_WR].pc;

endmodule

// File: rtl/pl_hazard_unit.sv
module pl_hazard_unit #(
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              of_v,
  input  logic              of_src_en,
  input  logic [TAG_W-1:0]  of_src,
  input  logic              ex_v,
  input  logic              ex_dst_en,
  input  logic [TAG_W-1:0]  ex_dst,
  input  logic              ex_is_br,
  input  logic              ex_taken,
  input  logic [ADDR_W-1:0] ex_target,
  output logic              stall_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] redirect_o
);

  logic raw_hit;
  logic br_hit;

  // The write stage is not compared: its result is visible to the same-cycle read.
  assign raw_hit    = of_v && of_src_en && ex_v && ex_dst_en && (of_src == ex_dst);
  assign br_hit     = ex_v && ex_is_br && ex_taken;
  assign flush_o    = br_hit;
  assign stall_o    = raw_hit && !br_hit;
  assign redirect_o = ex_target;

endmodule

// File: rtl/pl_perf_ctr.sv
module pl_perf_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_evt,
  output logic [CNT_W-1:0] cyc_o,
  output logic [CNT_W-1:0] ret_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_o <= '0;
      ret_o <= '0;
    end else begin
      cyc_o <= cyc_o + 1'b1;
      if (retire_evt) ret_o <= ret_o + 1'b1;
    end
  end

endmodule

// File: rtl/pl_hazard_ctrl.sv
module pl_hazard_ctrl
  import pl_ctrl_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [TAG_W-1:0]  in_dst,
  input  logic              in_dst_en,
  input  logic [TAG_W-1:0]  in_src,
  input  logic              in_src_en,
  input  logic              in_is_br,
  input  logic              in_br_taken,
  input  logic [ADDR_W-1:0] in_br_target,
  output logic [5:0]        stage_valid,
  output logic              stall,
  output logic              flush,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic [ADDR_W-1:0] wr_pc,
  output logic [CNT_W-1:0]  cycle_cnt,
  output logic [CNT_W-1:0]  retired_cnt
);

  logic [NUM_ST-1:0] v_all;
  logic              of_src_en, ex_dst_en, ex_is_br, ex_taken;
  logic [TAG_W-1:0]  of_src, ex_dst;
  logic [ADDR_W-1:0] ex_target;
  logic              accept;

  assign in_ready    = !stall && !flush;
  assign accept      = in_valid && in_ready;
  assign stage_valid = v_all;

  pl_stage_pipe #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hold(stall), .kill(flush),
    .d_pc(in_pc), .d_dst(in_dst), .d_dst_en(in_dst_en), .d_src(in_src),
    .d_src_en(in_src_en), .d_is_br(in_is_br), .d_taken(in_br_taken),
    .d_target(in_br_target), .v_o(v_all), .of_src_en(of_src_en), .of_src(of_src),
    .ex_dst_en(ex_dst_en), .ex_dst(ex_dst), .ex_is_br(ex_is_br), .ex_taken(ex_taken),
    .ex_target(ex_target), .wr_pc_o(wr_pc)
  );

  pl_hazard_unit #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_haz (
    .of_v(v_all[IDX_OF]), .of_src_en(of_src_en), .of_src(of_src),
    .ex_v(v_all[IDX_EX]), .ex_dst_en(ex_dst_en), .ex_dst(ex_dst),
    .ex_is_br(ex_is_br), .ex_taken(ex_taken), .ex_target(ex_target),
    .stall_o(stall), .flush_o(flush), .redirect_o(redirect_pc)
  );

  pl_perf_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .retire_evt(v_all[IDX_EX]),
    .cyc_o(cycle_cnt), .ret_o(retired_cnt)
  );

endmodule

// File: rtl/pl_hazard_ctrl_chk.sv
module pl_hazard_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [5:0]       stage_valid,
  input logic             stall,
  input logic             flush,
  input logic [CNT_W-1:0] cycle_cnt,
  input logic [CNT_W-1:0] retired_cnt
);

  // R9
  stall_flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && flush));

  // R5
  front_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> stage_valid[3:0] == $past(stage_valid[3:0]));

  // R5
  ex_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stage_valid[4]);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> stage_valid[4:0] == 5'b0);

  // R2
  wr_follows_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[4] |=> stage_valid[5]);

  // R2
  accept_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> stage_valid[0]);

  // R11
  retire_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[4] |=> retired_cnt == CNT_W'($past(retired_cnt) + 1'b1));

  // R11
  cycle_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cycle_cnt == CNT_W'($past(cycle_cnt) + 1'b1));

endmodule

bind pl_hazard_ctrl pl_hazard_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .stage_valid(stage_valid), .stall(stall), .flush(flush),
  .cycle_cnt(cycle_cnt), .retired_cnt(retired_cnt)
);

// File: tb/pl_hazard_ctrl_tb.sv
module pl_hazard_ctrl_tb;
  localparam int TAG_W = 4, ADDR_W = 16, CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic in_valid = 0, in_dst_en = 0, in_src_en = 0, in_is_br = 0, in_br_taken = 0;
  logic [ADDR_W-1:0] in_pc = '0, in_br_target = '0;
  logic [TAG_W-1:0] in_dst = '0, in_src = '0;
  logic in_ready, stall, flush;
  logic [5:0] stage_valid;
  logic [ADDR_W-1:0] redirect_pc, wr_pc;
  logic [CNT_W-1:0] cycle_cnt, retired_cnt;

  pl_hazard_ctrl #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
    .in_dst(in_dst), .in_dst_en(in_dst_en), .in_src(in_src), .in_src_en(in_src_en),
    .in_is_br(in_is_br), .in_br_taken(in_br_taken), .in_br_target(in_br_target),
    .stage_valid(stage_valid), .stall(stall), .flush(flush), .redirect_pc(redirect_pc),
    .wr_pc(wr_pc), .cycle_cnt(cycle_cnt), .retired_cnt(retired_cnt)
  );

  int checks = 0, fails = 0;
  int n_stall = 0, n_flush = 0;
  logic [ADDR_W-1:0] last_rt = '0;
  bit done = 0;

  // reference model state, one entry per stage
  logic m_v [6], m_de [6], m_se [6], m_br [6], m_tk [6];
  logic [ADDR_W-1:0] m_pc [6], m_tg [6];
  logic [TAG_W-1:0] m_dst [6], m_src [6];
  int m_cyc = 0, m_ret = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic mdl_flush();
    return m_v[4] && m_br[4] && m_tk[4];
  endfunction

  function automatic logic mdl_stall();
    return !mdl_flush() && m_v[3] && m_se[3] && m_v[4] && m_de[4] && (m_src[3] == m_dst[4]);
  endfunction

  task automatic mcp(input int d, input int s);
    m_v[d] = m_v[s]; m_pc[d] = m_pc[s]; m_dst[d] = m_dst[s]; m_de[d] = m_de[s];
    m_src[d] = m_src[s]; m_se[d] = m_se[s]; m_br[d] = m_br[s]; m_tk[d] = m_tk[s];
    m_tg[d] = m_tg[s];
  endtask

  task automatic mdl_adv(input logic acc);
    logic f, s;
    f = mdl_flush();
    s = mdl_stall();
    mcp(5, 4);
    if (f || s) m_v[4] = 1'b0; else mcp(4, 3);
    if (f) begin
      for (int k = 0; k < 4; k++) m_v[k] = 1'b0;
    end else if (!s) begin
      mcp(3, 2); mcp(2, 1); mcp(1, 0);
      m_v[0] = acc; m_pc[0] = in_pc; m_dst[0] = in_dst; m_de[0] = in_dst_en;
      m_src[0] = in_src; m_se[0] = in_src_en; m_br[0] = in_is_br;
      m_tk[0] = in_br_taken; m_tg[0] = in_br_target;
    end
    m_cyc++;
    if (m_v[5]) m_ret++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    for (int k = 0; k < 6; k++) m_v[k] = 1'b0;
    m_cyc = 0; m_ret = 0; n_stall = 0; n_flush = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(stage_valid === 6'b0, "R1", "stage_valid", stage_valid, 0);
    chk(stall === 1'b0 && flush === 1'b0, "R1", "stall|flush", {stall, flush}, 0);
    chk(cycle_cnt === '0 && retired_cnt === '0, "R1", "counters", cycle_cnt + retired_cnt, 0);
    chk(in_ready === 1'b1, "R1", "in_ready", in_ready, 1);
  endtask

  // one clock: called just after a falling edge with inputs already driven
  task automatic step(output logic acc, output logic fl, output logic [ADDR_W-1:0] rt);
    logic s, rdy;
    #1;
    fl = mdl_flush(); s = mdl_stall(); rdy = !fl && !s;
    acc = in_valid && rdy; rt = m_tg[4];
    chk(stall === s, "R4", "stall", stall, s);
    chk(flush === fl, "R7", "flush", flush, fl);
    chk(in_ready === rdy, "R2", "in_ready", in_ready, rdy);
    if (fl) chk(redirect_pc === m_tg[4], "R7", "redirect_pc", redirect_pc, m_tg[4]);
    if (stall === 1'b1) n_stall++;
    if (flush === 1'b1) begin n_flush++; last_rt = redirect_pc; end
    mdl_adv(acc);
    @(posedge clk); #1;
    for (int k = 0; k < 6; k++)
      chk(stage_valid[k] === m_v[k], (s || fl) ? "R5/R8" : "R2", "stage_valid bit",
          stage_valid[k], m_v[k]);
    if (m_v[5]) chk(wr_pc === m_pc[5], "R2", "wr_pc", wr_pc, m_pc[5]);
    chk(cycle_cnt === CNT_W'(m_cyc), "R11", "cycle_cnt", cycle_cnt, m_cyc);
    chk(retired_cnt === CNT_W'(m_ret), "R11", "retired_cnt", retired_cnt, m_ret);
    @(negedge clk);
  endtask

  task automatic drv(input logic v, input int pc, input int dst, input logic de,
                     input int src, input logic se, input logic br, input logic tk, input int tg);
    in_valid = v; in_pc = ADDR_W'(pc); in_dst = TAG_W'(dst); in_dst_en = de;
    in_src = TAG_W'(src); in_src_en = se; in_is_br = br; in_br_taken = tk;
    in_br_target = ADDR_W'(tg);
  endtask

  task automatic issue(input int pc, input int dst, input logic de, input int src,
                       input logic se, input logic br, input logic tk, input int tg);
    logic a, f;
    logic [ADDR_W-1:0] r;
    drv(1'b1, pc, dst, de, src, se, br, tk, tg);
    do step(a, f, r); while (!a && !f);
  endtask

  task automatic idle(input int n);
    logic a, f;
    logic [ADDR_W-1:0] r;
    drv(1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) step(a, f, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);

    // R3: nine independent instructions, back to back
    do_reset();
    for (int i = 0; i < 9; i++) issue(i, 0, 0, 0, 0, 0, 0, 0);
    idle(5);
    chk(cycle_cnt === 14, "R3", "cycle_cnt at last write", cycle_cnt, 14);
    chk(retired_cnt === 9, "R3", "retired_cnt at cycle 14", retired_cnt, 9);
    chk(stage_valid[5] === 1'b1 && wr_pc === 8, "R3", "wr_pc", wr_pc, 8);

    // R4: adjacent dependency stalls exactly one cycle
    do_reset();
    issue(1, 3, 1, 0, 0, 0, 0, 0);
    issue(2, 0, 0, 3, 1, 0, 0, 0);
    idle(8);
    chk(n_stall == 1, "R4", "stall cycles", n_stall, 1);
    chk(retired_cnt === 2, "R5", "retired after stall", retired_cnt, 2);

    // R6: distance two, write stage match only
    do_reset();
    issue(1, 2, 1, 0, 0, 0, 0, 0);
    issue(2, 7, 1, 9, 1, 0, 0, 0);
    issue(3, 0, 0, 2, 1, 0, 0, 0);
    idle(8);
    chk(n_stall == 0, "R6", "stall cycles", n_stall, 0);

    // R7/R8: taken branch discards three younger instructions
    do_reset();
    issue(10, 0, 0, 0, 0, 1, 1, 100);
    for (int i = 11; i < 14; i++) issue(i, 0, 0, 0, 0, 0, 0, 0);
    idle(8);
    chk(n_flush == 1, "R7", "flush cycles", n_flush, 1);
    chk(last_rt === 100, "R7", "redirect_pc", last_rt, 100);
    chk(retired_cnt === 1, "R8", "retired after flush", retired_cnt, 1);

    // R9: flush and dependency in the same cycle
    do_reset();
    issue(20, 5, 1, 0, 0, 1, 1, 200);
    issue(21, 0, 0, 5, 1, 0, 0, 0);
    idle(8);
    chk(n_stall == 0, "R9", "stall cycles", n_stall, 0);
    chk(n_flush == 1, "R9", "flush cycles", n_flush, 1);
    chk(retired_cnt === 1, "R9", "retired", retired_cnt, 1);

    // R10: not-taken branch
    do_reset();
    issue(30, 0, 0, 0, 0, 1, 0, 300);
    for (int i = 31; i < 35; i++) issue(i, 0, 0, 0, 0, 0, 0, 0);
    idle(8);
    chk(n_flush == 0, "R10", "flush cycles", n_flush, 0);
    chk(retired_cnt === 5, "R10", "retired", retired_cnt, 5);

    // random fetch source
    do_reset();
    begin
      bit pend = 0;
      int next_pc = 0;
      logic a, f;
      logic [ADDR_W-1:0] r;
      for (int c = 0; c < 3000; c++) begin
        if (!pend && ($urandom % 4 != 0)) begin
          pend = 1;
          drv(1'b1, next_pc, $urandom % 4, $urandom % 2, $urandom % 4, $urandom % 2,
              ($urandom % 8) == 0, $urandom % 2, $urandom % 65536);
          next_pc++;
        end
        in_valid = pend;
        step(a, f, r);
        if (a) pend = 0;
        if (f) begin pend = 0; next_pc = int'(r); end
      end
      idle(8);
    end
    chk(n_stall > 0 && n_flush > 0, "R4", "random run saw stalls and flushes", n_stall, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule